// File: doc/BRIEF.md
# I2C Master Bit Engine with Bus Recovery

This block is the bit-level layer of a single-master I2C controller. A higher-level sequencer hands it one command at a time: generate a START, generate a STOP, shift a byte out and collect the acknowledge, shift a byte in and answer with a chosen acknowledge level, or recover a hung bus. The engine turns each command into a timed series of SCL and SDA line states. Both lines are open-drain: the block only ever asserts a pull-low enable, and an external pull-up supplies the high level.

All timing comes from one quantum, the unit, whose length in system clocks is set at run time on `unit_len`. Every step of every command lasts one unit, and a data bit spans four units: SCL low, SDA update, SCL high, SCL held high. The recovery command clocks SCL nine times with SDA released, which lets a slave stuck mid-byte finish shifting out, and then it issues a full STOP so that the bus ends idle.

The sequencer pulses `cmd_valid` while `busy` is low. When the command finishes, `done` pulses for one cycle, and `rdata` and `ack_in` carry the results.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset, `scl_oe` and `sda_oe` are 0 (both lines released), and `busy` and `done` are 0.
- R2: Command codes on `cmd_op` are: 0 START, 1 STOP, 2 WRITE, 3 READ, 4 RECOVER; codes 5 to 7 are not accepted. A command is accepted on a clock edge where `cmd_valid` is 1 and `busy` is 0, and `busy` is 1 from that edge until completion. `cmd_valid` is ignored while `busy` is 1.
- R3: Completion is marked by `done` high for exactly one cycle. `busy` is 0 in that cycle, and `rdata` and `ack_in` hold the command's results.
- R4: One unit lasts `unit_len` clocks, and a value of 0 counts as 1. During WRITE, READ and RECOVER, SCL stays high for two units per clock pulse.
- R5: START drives an SDA falling edge while SCL is high. It ends with SCL released and SDA pulled low.
- R6: STOP pulls SCL low, pulls SDA low, releases SCL, then releases SDA, one unit per step. This gives an SDA rising edge while SCL is high, and it ends with both lines released.
- R7: WRITE sends `cmd_wdata` MSB first on eight SCL pulses. SDA changes only while SCL is low.
- R8: On the ninth SCL pulse of a WRITE, the engine releases SDA and samples it before SCL falls. `ack_in` is the sampled level: 0 is ACK, 1 is NACK.
- R9: READ releases SDA for eight SCL pulses and samples each bit one unit after the SCL rising edge. The bits are assembled MSB first into `rdata`.
- R10: On the ninth SCL pulse of a READ, SDA carries `cmd_ack_lvl`. A value of 0 pulls SDA low to continue; a value of 1 releases it (NACK).
- R11: RECOVER gives nine SCL pulses with SDA released, then a full STOP. It gives a single `done` at the end, with both lines released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| unit_len | input | DIV_W | Clocks per timing unit (0 treated as 1) |
| cmd_valid | input | 1 | Command request strobe |
| cmd_op | input | 3 | Command code |
| cmd_wdata | input | 8 | Byte to transmit for WRITE |
| cmd_ack_lvl | input | 1 | Acknowledge level driven after a READ (1 = NACK) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte received by READ |
| ack_in | output | 1 | Acknowledge sampled after WRITE (1 = NACK) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Resolved SDA line level |

## Verification
The bench builds the engine with the default `DIV_W` of 8 and changes `unit_len` at run time through 3, 1, 0 and 2. The short units keep each run small. They also reach the one-clock-per-unit case, where every line update and every SDA sample falls on consecutive edges, and the zero setting, which must behave like one. A bus model resolves SDA as wired-AND with a reactive slave, so ACK, NACK, slave-driven read data and the master's own acknowledge all appear on the shared line, where a monitor checks them.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_STOP    = 3'd1,
        OP_WRITE   = 3'd2,
        OP_READ    = 3'd3,
        OP_RECOVER = 3'd4
    } op_e;

    localparam int BYTE_W     = 8;
    localparam int BIT_CNT_W  = 4;
    localparam int ACK_SLOT   = 8;   // ninth clock pulse
    localparam int TAIL_SLOT  = 9;   // trailing SCL-low unit
    localparam int RECOV_LAST = 8;   // last recovery pulse index

    typedef struct packed {
        logic                 busy;
        logic                 done;
        op_e                  op;
        logic [BIT_CNT_W-1:0] slot;
        logic [1:0]           ph;
        logic                 scl_low;
        logic                 sda_low;
        logic                 ack_lvl;
        logic                 ack_in;
    } eng_t;

endpackage

// File: rtl/i2c_unit_timer.sv
module i2c_unit_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] unit_len,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] len_m1;

    always_comb begin
        len_m1 = (unit_len == '0) ? '0 : unit_len - 1'b1;
        tick   = run && !restart && (cnt_q == '0);
        cnt_d  = cnt_q;
        if (restart || tick) begin
            cnt_d = len_m1;
        end else if (run) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(run) || $past(restart)) else $error("tick while idle"); // R4

endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load)       sh_d = load_val;
        else if (shift) sh_d = {sh_q[W-2:0], sin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q;

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
    import i2c_eng_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] unit_len,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [7:0]       cmd_wdata,
    input  logic             cmd_ack_lvl,
    output logic             busy,
    output logic             done,
    output logic [7:0]       rdata,
    output logic             ack_in,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             sda_i
);
    eng_t s_d, s_q;
    logic accept, tick, last_unit, recov_wrap;
    logic sh_shift, sh_sin;
    logic [BYTE_W-1:0] sh_q;

    // Line state on entry to a unit; result is {scl_low, sda_low}.
    function automatic logic [1:0] unit_lines(
        input op_e op, input logic [BIT_CNT_W-1:0] b, input logic [1:0] p,
        input logic scl_l, input logic sda_l, input logic txb, input logic al);
        logic sc, sd, bitv;
        sc = scl_l;
        sd = sda_l;
        case (op)
            OP_START: begin
                case (p)
                    2'd0:    sd = 1'b0;
                    2'd1:    begin sc = 1'b0; sd = 1'b0; end
                    default: begin sc = 1'b0; sd = 1'b1; end
                endcase
            end
            OP_STOP: begin
                case (p)
                    2'd0:    sc = 1'b1;
                    2'd1:    begin sc = 1'b1; sd = 1'b1; end
                    2'd2:    begin sc = 1'b0; sd = 1'b1; end
                    default: begin sc = 1'b0; sd = 1'b0; end
                endcase
            end
            default: begin
                if (op == OP_WRITE)     bitv = (b < BIT_CNT_W'(ACK_SLOT)) ? !txb : 1'b0;
                else if (op == OP_READ) bitv = (b < BIT_CNT_W'(ACK_SLOT)) ? 1'b0 : !al;
                else                    bitv = 1'b0;
                if (b == BIT_CNT_W'(TAIL_SLOT)) begin
                    sc = 1'b1;
                end else begin
                    case (p)
                        2'd0:    sc = 1'b1;
                        2'd1:    begin sc = 1'b1; sd = bitv; end
                        2'd2:    sc = 1'b0;
                        default: ;
                    endcase
                end
                if (op == OP_RECOVER) sd = 1'b0;
            end
        endcase
        return {sc, sd};
    endfunction

    i2c_unit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(accept), .run(s_q.busy),
        .unit_len(unit_len), .tick(tick)
    );

    i2c_byte_shift #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_val(cmd_wdata),
        .shift(sh_shift), .sin(sh_sin), .q(sh_q)
    );

    always_comb begin
        logic [BIT_CNT_W-1:0] nb;
        logic [1:0]           np;
        logic                 txb;
        s_d        = s_q;
        s_d.done   = 1'b0;
        accept     = cmd_valid && !s_q.busy && (cmd_op <= 3'd4);
        last_unit  = (s_q.op == OP_START && s_q.ph == 2'd2) ||
                     (s_q.op == OP_STOP  && s_q.ph == 2'd3) ||
                     ((s_q.op == OP_WRITE || s_q.op == OP_READ) &&
                      s_q.slot == BIT_CNT_W'(TAIL_SLOT));
        recov_wrap = (s_q.op == OP_RECOVER) && (s_q.slot == BIT_CNT_W'(RECOV_LAST)) &&
                     (s_q.ph == 2'd3);
        sh_shift   = tick && (s_q.slot < BIT_CNT_W'(ACK_SLOT)) &&
                     ((s_q.op == OP_WRITE && s_q.ph == 2'd3) ||
                      (s_q.op == OP_READ  && s_q.ph == 2'd2));
        sh_sin     = (s_q.op == OP_READ) ? sda_i : 1'b0;
        nb         = s_q.slot;
        np         = s_q.ph;
        txb        = sh_q[BYTE_W-1];

        if (accept) begin
            s_d.busy    = 1'b1;
            s_d.op      = op_e'(cmd_op);
            s_d.slot    = '0;
            s_d.ph      = '0;
            s_d.ack_lvl = cmd_ack_lvl;
            {s_d.scl_low, s_d.sda_low} = unit_lines(op_e'(cmd_op), '0, '0,
                s_q.scl_low, s_q.sda_low, cmd_wdata[BYTE_W-1], cmd_ack_lvl);
        end else if (tick) begin
            if (s_q.op == OP_WRITE && s_q.slot == BIT_CNT_W'(ACK_SLOT) && s_q.ph == 2'd3)
                s_d.ack_in = sda_i;
            if (last_unit) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else if (recov_wrap) begin
                s_d.op   = OP_STOP;
                s_d.slot = '0;
                s_d.ph   = '0;
                {s_d.scl_low, s_d.sda_low} = unit_lines(OP_STOP, '0, '0,
                    s_q.scl_low, s_q.sda_low, 1'b0, 1'b0);
            end else begin
                if (s_q.ph == 2'd3) begin
                    nb  = s_q.slot + 1'b1;
                    np  = '0;
                    txb = sh_q[BYTE_W-2];
                end else begin
                    np  = s_q.ph + 1'b1;
                end
                s_d.slot = nb;
                s_d.ph   = np;
                {s_d.scl_low, s_d.sda_low} = unit_lines(s_q.op, nb, np,
                    s_q.scl_low, s_q.sda_low, txb, s_q.ack_lvl);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.op      <= OP_STOP;
            s_q.ack_lvl <= 1'b1;
            s_q.ack_in  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy   = s_q.busy;
    assign done   = s_q.done;
    assign rdata  = sh_q;
    assign ack_in = s_q.ack_in;
    assign scl_oe = s_q.scl_low;
    assign sda_oe = s_q.sda_low;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done wider than one cycle"); // R3
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy) else $error("done while busy"); // R3
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done) else $error("busy dropped without done"); // R2
    AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(s_q.op) == s_q.op &&
         (s_q.op == OP_WRITE || s_q.op == OP_READ || s_q.op == OP_RECOVER) &&
         !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe))
        else $error("SDA moved while SCL high in data phase"); // R7
    AST_START_END_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && s_q.op == OP_START) |-> (!scl_oe && sda_oe))
        else $error("START ended in wrong line state"); // R5
    AST_STOP_END_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && s_q.op == OP_STOP) |-> (!scl_oe && !sda_oe))
        else $error("STOP left a line pulled"); // R6

endmodule

// File: tb/sim_i2c_bit_engine.sv
module sim_i2c_bit_engine;
    localparam int DIV_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DIV_W-1:0] unit_len = 8'd3;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_wdata = 8'd0;
    logic cmd_ack_lvl = 1'b0;
    logic busy, done, ack_in, scl_oe, sda_oe, sda_i;
    logic [7:0] rdata;

    always #10 clk = ~clk;   // 50 MHz

    i2c_bit_engine #(.DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .unit_len(unit_len), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_ack_lvl(cmd_ack_lvl),
        .busy(busy), .done(done), .rdata(rdata), .ack_in(ack_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_i)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- slave model and wired-AND bus ----------------
    logic [1:0] slv_mode = 2'd0;    // 0 idle, 1 ack writer, 2 transmit byte
    logic [7:0] slv_tx = 8'd0;
    logic       slv_ack = 1'b0;
    logic       slv_clr = 1'b0;
    logic [3:0] slot = 4'd0;
    logic       risen = 1'b0;
    logic       scl_prev_s = 1'b1;
    logic       slv_low;
    logic [2:0] slv_idx;

    assign slv_idx = 3'd7 - slot[2:0];
    assign slv_low = (slv_mode == 2'd1 && slot == 4'd8 && !slv_ack) ||
                     (slv_mode == 2'd2 && slot < 4'd8 && !slv_tx[slv_idx]);
    assign sda_i   = !(sda_oe || slv_low);

    always @(posedge clk) begin
        scl_prev_s <= !scl_oe;
        if (slv_clr) begin
            slot  <= 4'd0;
            risen <= 1'b0;
        end else if (!scl_prev_s && !scl_oe) begin
            risen <= 1'b1;
        end else if (scl_prev_s && scl_oe && risen) begin
            slot  <= slot + 4'd1;
            risen <= 1'b0;
        end
    end

    // ---------------- bus monitor ----------------
    logic scl_p = 1'b1, sda_p = 1'b1;
    logic [8:0] cap = 9'd0;
    int rises = 0, low_rises = 0, starts = 0, stops = 0;
    int hi_cnt = 0, hi_len = 0;

    always @(negedge clk) begin
        logic scl_l, sda_l;
        scl_l = !scl_oe;
        sda_l = sda_i;
        if (scl_l && !scl_p) begin
            rises++;
            cap = {cap[7:0], sda_l};
            if (!sda_l) low_rises++;
        end
        if (scl_l && scl_p && sda_p && !sda_l) starts++;
        if (scl_l && scl_p && !sda_p && sda_l) stops++;
        if (scl_l) hi_cnt++;
        else if (scl_p) begin hi_len = hi_cnt; hi_cnt = 0; end
        scl_p = scl_l;
        sda_p = sda_l;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [2:0] op;
        logic [7:0] rd;
        logic       ack;
        logic       chk_rd;
        logic       chk_ack;
    } exp_t;
    exp_t exp_q[$];
    int done_run = 0, done_max = 0, done_seen = 0;

    always @(negedge clk) begin
        if (done) begin
            exp_t e;
            done_run++;
            done_seen++;
            chk(!busy, "R3 busy low at done", int'(busy), 0);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected completion", 1, 0);
            end else begin
                e = exp_q.pop_front();
                if (e.chk_rd)  chk(rdata == e.rd, "R9 read byte", rdata, e.rd);
                if (e.chk_ack) chk(ack_in == e.ack, "R8 sampled ack", ack_in, e.ack);
            end
        end else begin
            done_run = 0;
        end
        if (done_run > done_max) done_max = done_run;
    end

    task automatic push(input logic [2:0] op, input logic [7:0] rd, input logic ack,
                        input logic crd, input logic cack);
        exp_t e;
        e.op = op; e.rd = rd; e.ack = ack; e.chk_rd = crd; e.chk_ack = cack;
        exp_q.push_back(e);
    endtask

    task automatic issue(input logic [2:0] op, input logic [7:0] wd, input logic al,
                         input logic [1:0] smode, input logic [7:0] stx, input logic sack);
        @(negedge clk);
        slv_mode = smode; slv_tx = stx; slv_ack = sack;
        cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd; cmd_ack_lvl = al; slv_clr = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; slv_clr = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int r0, s0, p0, d0;
        repeat (3) @(negedge clk);
        chk(!scl_oe && !sda_oe, "R1 lines released at reset", {scl_oe, sda_oe}, 0);
        chk(!busy && !done, "R1 busy/done low at reset", {busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // START
        s0 = starts;
        push(3'd0, 8'd0, 1'b0, 1'b0, 1'b0);
        issue(3'd0, 8'd0, 1'b0, 2'd0, 8'd0, 1'b0);
        chk(starts == s0 + 1, "R5 start condition seen", starts, s0 + 1);
        chk(!scl_oe && sda_oe, "R5 start end state", {scl_oe, sda_oe}, 1);

        // WRITE with ACK, unit_len 3
        push(3'd2, 8'd0, 1'b0, 1'b0, 1'b1);
        issue(3'd2, 8'hA5, 1'b0, 2'd1, 8'd0, 1'b0);
        chk(cap[8:1] == 8'hA5, "R7 write byte on bus", cap[8:1], 8'hA5);
        chk(cap[0] == 1'b0, "R8 ack on ninth pulse", cap[0], 0);
        chk(hi_len == 6, "R4 SCL high two units (len 3)", hi_len, 6);

        // WRITE with NACK
        push(3'd2, 8'd0, 1'b1, 1'b0, 1'b1);
        issue(3'd2, 8'h5A, 1'b0, 2'd1, 8'd0, 1'b1);
        chk(cap[8:1] == 8'h5A, "R7 second write byte", cap[8:1], 8'h5A);
        chk(ack_in == 1'b1, "R8 nack reported", ack_in, 1);

        // READ with ACK
        push(3'd3, 8'h3C, 1'b0, 1'b1, 1'b0);
        issue(3'd3, 8'h00, 1'b0, 2'd2, 8'h3C, 1'b0);
        chk(cap[0] == 1'b0, "R10 master ack low", cap[0], 0);

        // READ with NACK
        push(3'd3, 8'hC3, 1'b0, 1'b1, 1'b0);
        issue(3'd3, 8'h00, 1'b1, 2'd2, 8'hC3, 1'b0);
        chk(cap[0] == 1'b1, "R10 master nack high", cap[0], 1);
        chk(cap[8:1] == 8'hC3, "R9 read bits on bus", cap[8:1], 8'hC3);

        // STOP
        p0 = stops;
        push(3'd1, 8'd0, 1'b0, 1'b0, 1'b0);
        issue(3'd1, 8'd0, 1'b0, 2'd0, 8'd0, 1'b0);
        chk(stops == p0 + 1, "R6 stop condition seen", stops, p0 + 1);
        chk(!scl_oe && !sda_oe, "R6 lines released after stop", {scl_oe, sda_oe}, 0);

        // unit_len 1 and 0
        unit_len = 8'd1;
        push(3'd0, 8'd0, 1'b0, 1'b0, 1'b0);
        issue(3'd0, 8'd0, 1'b0, 2'd0, 8'd0, 1'b0);
        push(3'd2, 8'd0, 1'b0, 1'b0, 1'b1);
        issue(3'd2, 8'h81, 1'b0, 2'd1, 8'd0, 1'b0);
        chk(hi_len == 2, "R4 SCL high two units (len 1)", hi_len, 2);
        chk(cap[8:1] == 8'h81, "R7 write at len 1", cap[8:1], 8'h81);
        push(3'd3, 8'h96, 1'b0, 1'b1, 1'b0);
        issue(3'd3, 8'h00, 1'b1, 2'd2, 8'h96, 1'b0);
        unit_len = 8'd0;
        push(3'd2, 8'd0, 1'b0, 1'b0, 1'b1);
        issue(3'd2, 8'h7E, 1'b0, 2'd1, 8'd0, 1'b0);
        chk(hi_len == 2, "R4 zero length acts as one", hi_len, 2);

        // busy ignore: STOP request during WRITE
        unit_len = 8'd2;
        d0 = done_seen;
        p0 = stops;
        push(3'd2, 8'd0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        slv_mode = 2'd1; slv_ack = 1'b0;
        cmd_valid = 1'b1; cmd_op = 3'd2; cmd_wdata = 8'hC9; slv_clr = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; slv_clr = 1'b0;
        repeat (4) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        repeat (30) @(negedge clk);
        chk(done_seen == d0 + 1, "R2 request ignored while busy", done_seen, d0 + 1);
        chk(stops == p0, "R2 no stop from ignored request", stops, p0);
        chk(cap[8:1] == 8'hC9, "R2 write unaffected", cap[8:1], 8'hC9);

        // RECOVER after a START
        push(3'd0, 8'd0, 1'b0, 1'b0, 1'b0);
        issue(3'd0, 8'd0, 1'b0, 2'd0, 8'd0, 1'b0);
        r0 = rises; p0 = stops; d0 = low_rises; s0 = done_seen;
        push(3'd4, 8'd0, 1'b0, 1'b0, 1'b0);
        issue(3'd4, 8'd0, 1'b0, 2'd0, 8'd0, 1'b0);
        chk(rises - r0 == 10, "R11 nine pulses plus stop pulse", rises - r0, 10);
        chk(low_rises - d0 == 1, "R11 SDA high on recovery pulses", low_rises - d0, 1);
        chk(stops == p0 + 1, "R11 stop after recovery", stops, p0 + 1);
        chk(done_seen == s0 + 1, "R11 single completion", done_seen, s0 + 1);
        chk(!scl_oe && !sda_oe, "R11 lines released", {scl_oe, sda_oe}, 0);

        chk(done_max == 1, "R3 done one cycle wide", done_max, 1);
        chk(exp_q.size() == 0, "R3 all completions seen", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule